// File: doc/BRIEF.md
# Three-Rail Power Supervisor with Fault Interrupt

This block is the digital supervisor of a power manager with three supply rails. It turns synchronized thermal and undervoltage detector inputs, an external enable pin and register writes from a simple parallel bus into the three rail-enable outputs and an active-low interrupt line. It holds one control register, one status register and one output-voltage code register.

When either detector fires, all rails drop in the same cycle. The rail enables and the voltage code return to their defaults, and the sticky fault flags are set. A restart-policy bit is kept across the fault. If it is set, the rails come back by themselves once the detectors have stayed quiet for a short window. The enable pin and the bus can each cancel that restart. Software clears a flag by writing a one to it. If the condition behind a flag is still present, the flag stays set.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While `tsd_i` or `uvlo_i` is high, `rail_en_o` is 3'b000 in that same cycle, the stored rail enables are 0 after the next edge, and the matching flag is set after that edge (status bit 4 = thermal, bit 5 = undervoltage).
- R2: A fault reloads the voltage register (address 2) with `VSEL_DEF` and clears the sequencing bit (address 0, bit 4). It leaves the restart-policy bit (bit 5) and the interrupt-enable bit (bit 3) unchanged.
- R3: With the restart-policy bit at 1, the three rail enables turn on at the clock edge that follows two consecutive cycles with both detectors low after a fault.
- R4: With the restart-policy bit at 0, the rails stay off after the fault clears.
- R5: A high-to-low transition on `en_pin_i` clears the rail enables and cancels a pending restart. A low-to-high transition with no fault present turns all three rails on.
- R6: A bus write of zero to the rail-enable bits [2:0] of address 0 while a fault is active cancels the pending restart.
- R7: Fault flags are sticky. Writing a one to bit 4 or bit 5 of address 1 clears the corresponding flag when its condition is absent. Writing zeros has no effect.
- R8: Writing a one to a flag while its condition is still active leaves the flag set.
- R9: `irq_n_o` is low exactly when interrupt-enable (address 0, bit 3) is 1 and at least one fault flag is set. The restart-policy bit has no effect on it.
- R10: After reset the readouts are: address 0 = 0x20 (rails off, interrupt off, sequencing bit 0, restart policy 1), flags 0, address 2 = `VSEL_DEF`, `irq_n_o` high.
- R11: Status bits [2:0] read back the current `pg_i` rail power-good inputs.
- R12: Address 0 reads {2'b0, policy, seq, int_en, rails[2:0]}. Writes to it store bits [5:0]. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tsd_i | input | 1 | Synchronized over-temperature detect |
| uvlo_i | input | 1 | Synchronized undervoltage detect |
| en_pin_i | input | 1 | Synchronized external enable pin |
| pg_i | input | 3 | Per-rail power-good inputs |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| rail_en_o | output | 3 | Supply-rail enables |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The restart path is driven three ways. In one case the fault clears undisturbed with the policy bit set. In a second the policy bit is cleared. In a third the restart is cancelled either by a pin falling edge or by a zero write to the enables during the fault. Together these separate a restart that is qualified, one that is blocked, and one that is cancelled. The flags are cleared both while their condition is still present and after it has gone, which separates a true write-one-to-clear from a flag that only follows the detector. The interrupt is checked with interrupt-enable on and off while flags are set.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int N_RAIL = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_VSEL = 2'd2;

  // control register fields
  localparam int B_IEN  = 3;
  localparam int B_SEQ  = 4;
  localparam int B_POL  = 5;
  // status register fields
  localparam int B_TSD  = 4;
  localparam int B_UVLO = 5;

  typedef struct packed {
    logic              pol;
    logic              seq;
    logic              ien;
    logic [N_RAIL-1:0] rails;
  } ctrl_t;
endpackage

// File: rtl/pfs_restart_qual.sv
module pfs_restart_qual #(
  parameter int QUIET_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic cancel,
  input  logic policy,
  output logic restart
);
  localparam int CW = $clog2(QUIET_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  assign restart = armed_q && policy && !fault && (cnt_q == CW'(QUIET_CYC));

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (fault) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (cnt_q != CW'(QUIET_CYC)) begin
      cnt_d = cnt_q + CW'(1);
    end
    if (restart) armed_d = 1'b0;
    if (cancel)  armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  // R3: a restart only happens after the full quiet window
  p_quiet_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !$past(fault));
endmodule

// File: rtl/pfs_fault_flags.sv
module pfs_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tsd,
  input  logic uvlo,
  input  logic clr_tsd,
  input  logic clr_uvlo,
  output logic tsd_flag,
  output logic uvlo_flag
);
  logic tsd_d, uvlo_d;

  always_comb begin
    tsd_d  = tsd  | (tsd_flag  & ~clr_tsd);
    uvlo_d = uvlo | (uvlo_flag & ~clr_uvlo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsd_flag  <= 1'b0;
      uvlo_flag <= 1'b0;
    end else begin
      tsd_flag  <= tsd_d;
      uvlo_flag <= uvlo_d;
    end
  end

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd || uvlo) |=> (tsd_flag || uvlo_flag));
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_flag && !clr_tsd) |=> tsd_flag);
  p_clear_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && clr_uvlo) |=> uvlo_flag);
endmodule

// File: rtl/pfs_ctrl_regs.sv
module pfs_ctrl_regs
  import pfs_pkg::*;
#(
  parameter logic [DATA_W-1:0] VSEL_DEF = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault,
  input  logic              pin,
  input  logic              restart,
  input  logic              wr_ctrl,
  input  logic              wr_vsel,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] vsel,
  output logic              cancel
);
  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] vsel_d;
  logic              pin_q;
  logic              pin_fall, pin_rise;

  assign pin_fall = pin_q & ~pin;
  assign pin_rise = ~pin_q & pin;
  assign cancel   = pin_fall | (wr_ctrl && (wdata[N_RAIL-1:0] == '0));

  always_comb begin
    ctrl_d = ctrl;
    vsel_d = vsel;
    if (wr_ctrl) begin
      ctrl_d.ien = wdata[B_IEN];
      ctrl_d.seq = wdata[B_SEQ];
      ctrl_d.pol = wdata[B_POL];
      if (!fault) ctrl_d.rails = wdata[N_RAIL-1:0];
    end
    if (wr_vsel && !fault) vsel_d = wdata;
    if (pin_rise && !fault) ctrl_d.rails = '1;
    if (restart)            ctrl_d.rails = '1;
    if (pin_fall)           ctrl_d.rails = '0;
    if (fault) begin
      ctrl_d.rails = '0;
      ctrl_d.seq   = 1'b0;
      vsel_d       = VSEL_DEF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '{pol: 1'b1, seq: 1'b0, ien: 1'b0, rails: '0};
      vsel  <= VSEL_DEF;
      pin_q <= 1'b0;
    end else begin
      ctrl  <= ctrl_d;
      vsel  <= vsel_d;
      pin_q <= pin;
    end
  end

  p_fault_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (ctrl.rails == '0));
  p_fault_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (vsel == VSEL_DEF && !ctrl.seq));
  p_policy_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !wr_ctrl) |=> (ctrl.pol == $past(ctrl.pol)));
  p_pin_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> (ctrl.rails == '0));
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pfs_pkg::*;
#(
  parameter logic [DATA_W-1:0] VSEL_DEF  = 8'h40,
  parameter int                QUIET_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tsd_i,
  input  logic              uvlo_i,
  input  logic              en_pin_i,
  input  logic [N_RAIL-1:0] pg_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_RAIL-1:0] rail_en_o,
  output logic              irq_n_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] vsel;
  logic              fault, restart, cancel;
  logic              tsd_flag, uvlo_flag;
  logic              wr_ctrl, wr_vsel, wr_stat;

  assign fault   = tsd_i | uvlo_i;
  assign wr_ctrl = bus_we_i && (bus_addr_i == A_CTRL);
  assign wr_stat = bus_we_i && (bus_addr_i == A_STAT);
  assign wr_vsel = bus_we_i && (bus_addr_i == A_VSEL);

  pfs_ctrl_regs #(.VSEL_DEF(VSEL_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .fault(fault), .pin(en_pin_i),
    .restart(restart), .wr_ctrl(wr_ctrl), .wr_vsel(wr_vsel),
    .wdata(bus_wdata_i), .ctrl(ctrl), .vsel(vsel), .cancel(cancel));

  pfs_restart_qual #(.QUIET_CYC(QUIET_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .fault(fault), .cancel(cancel),
    .policy(ctrl.pol), .restart(restart));

  pfs_fault_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tsd(tsd_i), .uvlo(uvlo_i),
    .clr_tsd(wr_stat && bus_wdata_i[B_TSD]),
    .clr_uvlo(wr_stat && bus_wdata_i[B_UVLO]),
    .tsd_flag(tsd_flag), .uvlo_flag(uvlo_flag));

  // rails drop in the cycle the fault appears, ahead of the register
  assign rail_en_o = ctrl.rails & {N_RAIL{~fault}};
  assign irq_n_o   = ~(ctrl.ien & (tsd_flag | uvlo_flag));

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: bus_rdata_o = DATA_W'(ctrl);
      A_STAT: begin
        bus_rdata_o[N_RAIL-1:0] = pg_i;
        bus_rdata_o[B_TSD]      = tsd_flag;
        bus_rdata_o[B_UVLO]     = uvlo_flag;
      end
      A_VSEL: bus_rdata_o = vsel;
      default: bus_rdata_o = '0;
    endcase
  end

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ien |-> irq_n_o);
  p_rails_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) && fault |-> (rail_en_o == '0));
endmodule

// File: tb/sim_pwr_fault_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_fault_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tsd = 1'b0, uvlo = 1'b0, pin = 1'b0, we = 1'b0;
  logic [2:0] pg = '0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] rails;
  logic       irq_n;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_fault_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .tsd_i(tsd), .uvlo_i(uvlo), .en_pin_i(pin),
    .pg_i(pg), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .rail_en_o(rails), .irq_n_o(irq_n));

  typedef struct packed {
    logic       we;
    logic [1:0] addr;
    logic [7:0] wd;
    logic       tsd, uvlo, pin;
    logic [2:0] pg;
    logic [2:0] exp_rails;
    logic       exp_irqn;
    logic [7:0] exp_rd;
  } vec_t;

  // R5 rise, R12 write, R11 pg, R1 fault, R8 clear-while-active,
  // R5 fall cancels restart, R7 clear after fault gone
  localparam vec_t VEC [8] = '{
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1, 8'h27},
    '{1'b1, 2'd0, 8'h2F, 1'b0, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1, 8'h2F},
    '{1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b1, 3'b101, 3'b111, 1'b1, 8'h05},
    '{1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 1'b1, 3'b101, 3'b000, 1'b0, 8'h25},
    '{1'b1, 2'd1, 8'h20, 1'b0, 1'b1, 1'b1, 3'b101, 3'b000, 1'b0, 8'h25},
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b101, 3'b000, 1'b0, 8'h28},
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b101, 3'b000, 1'b0, 8'h28},
    '{1'b1, 2'd1, 8'h20, 1'b0, 1'b0, 1'b0, 3'b101, 3'b000, 1'b1, 8'h05}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1 chk(rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset readouts
    chk({5'b0, rails}, 8'h00, "R10 rails");
    chk({7'b0, irq_n}, 8'h01, "R10 irq_n");
    rd(2'd0, 8'h20, "R10 ctrl");
    rd(2'd1, 8'h00, "R10 status");
    rd(2'd2, 8'h40, "R10 vsel");
    rd(2'd3, 8'h00, "R12 unused address");

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      we = VEC[i].we; addr = VEC[i].addr; wdata = VEC[i].wd;
      tsd = VEC[i].tsd; uvlo = VEC[i].uvlo; pin = VEC[i].pin; pg = VEC[i].pg;
      @(negedge clk);
      chk({5'b0, rails}, {5'b0, VEC[i].exp_rails}, $sformatf("vec%0d rails", i));
      chk({7'b0, irq_n}, {7'b0, VEC[i].exp_irqn}, $sformatf("vec%0d irq_n", i));
      chk(rdata, VEC[i].exp_rd, $sformatf("vec%0d rdata", i));
      we = 1'b0;
    end
    pg = '0;

    // R3 restart with policy 1, R2 reload
    pin = 1'b1; @(negedge clk);
    chk({5'b0, rails}, 8'h07, "R5 pin rise");
    wr(2'd2, 8'h7A);
    wr(2'd0, 8'h3F);
    rd(2'd2, 8'h7A, "R12 vsel write");
    tsd = 1'b1;
    #1 chk({5'b0, rails}, 8'h00, "R1 same-cycle rails off");
    @(negedge clk);
    rd(2'd0, 8'h28, "R2 ctrl after fault");
    tsd = 1'b0;
    rd(2'd2, 8'h40, "R2 vsel reloaded");
    rd(2'd1, 8'h10, "R1 thermal flag");
    chk({7'b0, irq_n}, 8'h00, "R9 irq asserted");
    idle(2);
    chk({5'b0, rails}, 8'h00, "R3 rails still off in window");
    @(negedge clk);
    chk({5'b0, rails}, 8'h07, "R3 restart");
    wr(2'd1, 8'h10);
    rd(2'd1, 8'h00, "R7 thermal flag cleared");
    chk({7'b0, irq_n}, 8'h01, "R9 irq released");

    // R4 policy 0
    wr(2'd0, 8'h0F);
    tsd = 1'b1; @(negedge clk); tsd = 1'b0;
    idle(5);
    chk({5'b0, rails}, 8'h00, "R4 no restart");
    rd(2'd0, 8'h08, "R2 policy kept at 0");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h10, "R7 zero write ignored");
    wr(2'd1, 8'h10);

    // R6 bus cancel, R9 interrupt disabled
    wr(2'd0, 8'h27);
    uvlo = 1'b1; @(negedge clk);
    wr(2'd0, 8'h20);
    uvlo = 1'b0;
    idle(5);
    chk({5'b0, rails}, 8'h00, "R6 bus cancel");
    rd(2'd1, 8'h20, "R7 uvlo flag held");
    chk({7'b0, irq_n}, 8'h01, "R9 int_en off");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule